// File: doc/BRIEF.md
# Vector Loop State Register

This block holds the packed control word that steers vector execution. It also runs the nested loop that walks the elements of a vector and the sub-elements of each element. A requester issues one request per cycle. A request can read or write the whole state word, or read or set the maximum length, the length pointer or the sub-vector size on its own. Each field that is written is forced into its legal range, measured against the fields it depends on. The response appears one cycle later on a registered data port.

The length field does not hold a count. It names a scalar register, numbered 0 to 31. The caller supplies the contents of that register on a side input, and the block caches those contents as the element count. Register number zero turns vectorisation off: the count becomes one and every operation issues as a scalar operation. If the supplied contents lie outside the current maximum length, a length-set request raises an illegal-instruction pulse and the state is left as it was.

A step input advances the loop. The sub-element index moves on every step. When it wraps, the source and destination offsets move to the next element. After the last sub-step of the last element, a one-cycle done pulse is raised and all offsets return to zero. All sub-steps of one element share that element's source offset, so they share its single predicate bit.

Top module: `vec_loop_state`

## Requirements
- R1: After synchronous reset, the state word holds XLEN in the maximum-length field and zero everywhere else, the element count is 1, and rsp_valid, illegal and done are low.
- R2: The state word layout, from the least significant bit upward, is: maximum length [5:0], length pointer [11:6], source offset [17:12], destination offset [23:18], sub-vector size code [25:24], sub-element offset [27:26]. Bits 31:28 always read as zero, whatever was written to them.
- R3: A whole-word write (op 1) forces the maximum length into the range 1..XLEN.
- R4: A whole-word write forces the length pointer to at most 31. The element count becomes 1 if the pointer is 0. Otherwise it becomes the supplied register contents, forced into the range 1..(new maximum length).
- R5: A whole-word write limits the source and destination offsets to at most count-1, and limits the sub-element offset to at most the sub-vector code.
- R6: A maximum-length set (op 3) stores max(1, min(requested, current)), returns the old maximum length, and pulls the count and offsets down to the new limit. A maximum-length get is op 2.
- R7: A length-pointer set (op 5) stores the register number, returns the new number (not the old one), and caches the supplied contents as the count. A length-pointer get is op 4.
- R8: A length-pointer set with a number above 31, or with a nonzero number whose supplied contents are 0 or exceed the maximum length, pulses illegal for one cycle, changes no state, and returns the unchanged pointer.
- R9: A sub-vector set (op 7) stores bits [1:0] of the request as the size code (size minus one: 0 means 1, 3 means 4), returns the old code, and limits the sub-element offset to the new code. A sub-vector get is op 6. A whole-word read is op 0.
- R10: Every request gives rsp_valid and its response data in the cycle after it is accepted.
- R11: A step advances the sub-element index. When the index wraps from the size code back to 0, the source offset moves up by one and the destination offset moves up by one, returning to 0 after count-1.
- R12: The step that follows the last sub-element of the element at count-1 produces a one-cycle done pulse and sets all three offsets to zero.
- R13: scalar_mode is high when the length pointer is 0. A step that coincides with a request is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request code (see R2 to R9) |
| req_wdata | input | XLEN | Write value or register number |
| vl_reg_value | input | XLEN | Contents of the scalar register named by the request |
| step | input | 1 | Advance the loop by one sub-operation |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_data | output | XLEN | Response value |
| illegal | output | 1 | Illegal-instruction pulse |
| done | output | 1 | Loop finished pulse |
| state_word | output | XLEN | Current packed state |
| elem_count | output | 6 | Cached element count |
| src_idx | output | 6 | Current source element offset |
| dst_idx | output | 6 | Current destination element offset |
| sub_idx | output | 2 | Current sub-element offset |
| scalar_mode | output | 1 | Vectorisation disabled |

## Verification
On every cycle the assertions check the range invariants: maximum length within 1..XLEN, count within 1..maximum, offsets below their limits, and the reserved bits zero. They also check that an illegal pulse leaves the state untouched, that a read or a coinciding step moves nothing, and that a done pulse leaves all offsets at zero. The exact values that clamping produces, the old-versus-new return rule of each set request, and the full order of indices across a nested loop with wrapping destination offsets can only be shown by the bench's request sequences and step scenarios.

// File: rtl/vls_pkg.sv
package vls_pkg;

  localparam int OFFS_W  = 6;
  localparam int SUB_W   = 2;
  localparam int WORD_W  = 32;
  localparam logic [OFFS_W-1:0] VL_REG_LAST = 6'd31;

  // field positions (neighbours decode them)
  localparam int MV_LSB  = 0;
  localparam int VL_LSB  = 6;
  localparam int SRC_LSB = 12;
  localparam int DST_LSB = 18;
  localparam int SV_LSB  = 24;
  localparam int DSV_LSB = 26;

  typedef struct packed {
    logic [3:0]        rsvd;
    logic [SUB_W-1:0]  dsvoffs;
    logic [SUB_W-1:0]  subvl;
    logic [OFFS_W-1:0] destoffs;
    logic [OFFS_W-1:0] srcoffs;
    logic [OFFS_W-1:0] vl;
    logic [OFFS_W-1:0] maxvl;
  } vstate_t;

  typedef enum logic [2:0] {
    OP_RD_STATE  = 3'd0,
    OP_WR_STATE  = 3'd1,
    OP_GET_MVL   = 3'd2,
    OP_SET_MVL   = 3'd3,
    OP_GET_VL    = 3'd4,
    OP_SET_VL    = 3'd5,
    OP_GET_SUBVL = 3'd6,
    OP_SET_SUBVL = 3'd7
  } vls_op_e;

  function automatic logic [OFFS_W-1:0] offs_limit(input logic [OFFS_W-1:0] v,
                                                  input logic [OFFS_W-1:0] cnt);
    logic [OFFS_W-1:0] top;
    top = cnt - 6'd1;
    return (v > top) ? top : v;
  endfunction

  function automatic logic [SUB_W-1:0] sub_limit(input logic [SUB_W-1:0] v,
                                                 input logic [SUB_W-1:0] code);
    return (v > code) ? code : v;
  endfunction

endpackage

// File: rtl/vls_range_chk.sv
module vls_range_chk #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] val,
  input  logic [5:0]      limit,
  output logic [5:0]      clamped
);
  always_comb begin
    if (val == '0)
      clamped = 6'd1;
    else if (val > XLEN'(limit))
      clamped = limit;
    else
      clamped = val[5:0];
  end
endmodule

// File: rtl/vls_loop_step.sv
module vls_loop_step #(
  parameter int OFFS_W = 6,
  parameter int SUB_W  = 2
) (
  input  logic [OFFS_W-1:0] src,
  input  logic [OFFS_W-1:0] dst,
  input  logic [SUB_W-1:0]  sub,
  input  logic [SUB_W-1:0]  sub_code,
  input  logic [OFFS_W-1:0] cnt,
  output logic [OFFS_W-1:0] nxt_src,
  output logic [OFFS_W-1:0] nxt_dst,
  output logic [SUB_W-1:0]  nxt_sub,
  output logic              wrap
);
  logic [OFFS_W-1:0] last_el;
  logic              sub_end;
  logic              el_end;

  assign last_el = cnt - OFFS_W'(1);
  assign sub_end = (sub >= sub_code);
  assign el_end  = (src >= last_el);

  always_comb begin
    nxt_src = src;
    nxt_dst = dst;
    nxt_sub = sub;
    wrap    = 1'b0;
    if (!sub_end) begin
      nxt_sub = sub + SUB_W'(1);
    end else if (el_end) begin
      nxt_src = '0;
      nxt_dst = '0;
      nxt_sub = '0;
      wrap    = 1'b1;
    end else begin
      nxt_sub = '0;
      nxt_src = src + OFFS_W'(1);
      nxt_dst = (dst >= last_el) ? '0 : dst + OFFS_W'(1);
    end
  end
endmodule

// File: rtl/vls_req_unit.sv
module vls_req_unit
  import vls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  vstate_t         cur,
  input  logic [5:0]      cur_cnt,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] sreg,
  output vstate_t         nxt,
  output logic [5:0]      nxt_cnt,
  output logic            bad,
  output logic [XLEN-1:0] rsp
);
  localparam logic [5:0] MV_CAP = 6'(XLEN);

  logic [5:0] w_mv, w_vl, w_src, w_dst;
  logic [1:0] w_sv, w_dsv;
  logic [5:0] mv_w, vl_w, cnt_w, cnt_set, mv_new, cnt_mv;
  logic       set_ok;

  assign w_mv  = wdata[MV_LSB  +: 6];
  assign w_vl  = wdata[VL_LSB  +: 6];
  assign w_src = wdata[SRC_LSB +: 6];
  assign w_dst = wdata[DST_LSB +: 6];
  assign w_sv  = wdata[SV_LSB  +: 2];
  assign w_dsv = wdata[DSV_LSB +: 2];

  assign mv_w = (w_mv == 6'd0) ? 6'd1 : ((w_mv > MV_CAP) ? MV_CAP : w_mv);
  assign vl_w = (w_vl > VL_REG_LAST) ? VL_REG_LAST : w_vl;

  vls_range_chk #(.XLEN(XLEN)) u_chk_wr (
    .val(sreg), .limit(mv_w), .clamped(cnt_w)
  );

  vls_range_chk #(.XLEN(XLEN)) u_chk_set (
    .val(sreg), .limit(cur.maxvl), .clamped(cnt_set)
  );

  assign set_ok = (XLEN'(cnt_set) == sreg);

  always_comb begin
    if (wdata >= XLEN'(cur.maxvl)) mv_new = cur.maxvl;
    else if (wdata == '0)          mv_new = 6'd1;
    else                           mv_new = wdata[5:0];
  end
  assign cnt_mv = (cur_cnt > mv_new) ? mv_new : cur_cnt;

  always_comb begin
    nxt     = cur;
    nxt_cnt = cur_cnt;
    bad     = 1'b0;
    rsp     = '0;
    unique case (vls_op_e'(op))
      OP_RD_STATE: rsp = XLEN'(cur);
      OP_WR_STATE: begin
        rsp          = XLEN'(cur);
        nxt.maxvl    = mv_w;
        nxt.vl       = vl_w;
        nxt_cnt      = (vl_w == 6'd0) ? 6'd1 : cnt_w;
        nxt.srcoffs  = offs_limit(w_src, nxt_cnt);
        nxt.destoffs = offs_limit(w_dst, nxt_cnt);
        nxt.subvl    = w_sv;
        nxt.dsvoffs  = sub_limit(w_dsv, w_sv);
        nxt.rsvd     = '0;
      end
      OP_GET_MVL: rsp = XLEN'(cur.maxvl);
      OP_SET_MVL: begin
        rsp          = XLEN'(cur.maxvl);
        nxt.maxvl    = mv_new;
        nxt_cnt      = cnt_mv;
        nxt.srcoffs  = offs_limit(cur.srcoffs, cnt_mv);
        nxt.destoffs = offs_limit(cur.destoffs, cnt_mv);
      end
      OP_GET_VL: rsp = XLEN'(cur.vl);
      OP_SET_VL: begin
        if (wdata > XLEN'(VL_REG_LAST)) begin
          bad = 1'b1;
          rsp = XLEN'(cur.vl);
        end else if (wdata == '0) begin
          rsp          = '0;
          nxt.vl       = '0;
          nxt_cnt      = 6'd1;
          nxt.srcoffs  = '0;
          nxt.destoffs = '0;
        end else if (!set_ok) begin
          bad = 1'b1;
          rsp = XLEN'(cur.vl);
        end else begin
          rsp          = wdata;
          nxt.vl       = wdata[5:0];
          nxt_cnt      = cnt_set;
          nxt.srcoffs  = offs_limit(cur.srcoffs, cnt_set);
          nxt.destoffs = offs_limit(cur.destoffs, cnt_set);
        end
      end
      OP_GET_SUBVL: rsp = XLEN'(cur.subvl);
      OP_SET_SUBVL: begin
        rsp         = XLEN'(cur.subvl);
        nxt.subvl   = wdata[1:0];
        nxt.dsvoffs = sub_limit(cur.dsvoffs, wdata[1:0]);
      end
      default: rsp = '0;
    endcase
  end
endmodule

// File: rtl/vec_loop_state.sv
module vec_loop_state
  import vls_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [XLEN-1:0] req_wdata,
  input  logic [XLEN-1:0] vl_reg_value,
  input  logic            step,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data,
  output logic            illegal,
  output logic            done,
  output logic [XLEN-1:0] state_word,
  output logic [5:0]      elem_count,
  output logic [5:0]      src_idx,
  output logic [5:0]      dst_idx,
  output logic [1:0]      sub_idx,
  output logic            scalar_mode
);
  localparam vstate_t RST_STATE = '{rsvd: '0, dsvoffs: '0, subvl: '0,
                                    destoffs: '0, srcoffs: '0, vl: '0,
                                    maxvl: 6'(XLEN)};

  vstate_t         st_q, st_req;
  logic [5:0]      cnt_q, cnt_req;
  logic            req_bad;
  logic [XLEN-1:0] req_rsp;
  logic [5:0]      lp_src, lp_dst;
  logic [1:0]      lp_sub;
  logic            lp_wrap;
  logic            rsp_valid_q, illegal_q, done_q;
  logic [XLEN-1:0] rsp_data_q;

  vls_req_unit #(.XLEN(XLEN)) u_req (
    .cur(st_q), .cur_cnt(cnt_q), .op(req_op), .wdata(req_wdata),
    .sreg(vl_reg_value), .nxt(st_req), .nxt_cnt(cnt_req),
    .bad(req_bad), .rsp(req_rsp)
  );

  vls_loop_step #(.OFFS_W(OFFS_W), .SUB_W(SUB_W)) u_loop (
    .src(st_q.srcoffs), .dst(st_q.destoffs), .sub(st_q.dsvoffs),
    .sub_code(st_q.subvl), .cnt(cnt_q),
    .nxt_src(lp_src), .nxt_dst(lp_dst), .nxt_sub(lp_sub), .wrap(lp_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= RST_STATE;
      cnt_q       <= 6'd1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      illegal_q   <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      illegal_q   <= req_valid && req_bad;
      done_q      <= 1'b0;
      if (req_valid) begin
        rsp_data_q <= req_rsp;
        if (!req_bad) begin
          st_q  <= st_req;
          cnt_q <= cnt_req;
        end
      end else if (step) begin
        st_q.srcoffs  <= lp_src;
        st_q.destoffs <= lp_dst;
        st_q.dsvoffs  <= lp_sub;
        done_q        <= lp_wrap;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign illegal     = illegal_q;
  assign done        = done_q;
  assign state_word  = XLEN'(st_q);
  assign elem_count  = cnt_q;
  assign src_idx     = st_q.srcoffs;
  assign dst_idx     = st_q.destoffs;
  assign sub_idx     = st_q.dsvoffs;
  assign scalar_mode = (st_q.vl == '0);
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [2:0]      req_op,
  input logic            step,
  input logic            rsp_valid,
  input logic            illegal,
  input logic            done,
  input logic [XLEN-1:0] state_word,
  input logic [5:0]      elem_count,
  input logic [5:0]      src_idx,
  input logic [5:0]      dst_idx,
  input logic [1:0]      sub_idx
);
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (state_word == XLEN'(XLEN) && elem_count == 6'd1 &&
             !rsp_valid && !illegal && !done));

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    state_word[XLEN-1:28] == '0);

  a_r3_maxvl_range: assert property (@(posedge clk) disable iff (rst)
    state_word[5:0] >= 6'd1 && state_word[5:0] <= 6'(XLEN));

  a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
    elem_count >= 6'd1 && elem_count <= state_word[5:0] &&
    state_word[11:6] <= 6'd31);

  a_r5_offs_range: assert property (@(posedge clk) disable iff (rst)
    src_idx < elem_count && dst_idx < elem_count &&
    sub_idx <= state_word[25:24]);

  a_r8_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    illegal |-> state_word == $past(state_word));

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r11_sub_advance: assert property (@(posedge clk) disable iff (rst)
    (step && !req_valid && sub_idx != state_word[25:24]) |=>
      sub_idx == $past(sub_idx) + 2'd1);

  a_r12_done_clears: assert property (@(posedge clk) disable iff (rst)
    done |-> (src_idx == '0 && dst_idx == '0 && sub_idx == '0));

  a_r13_read_no_move: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op[0]) |=> $stable(state_word));
endmodule

bind vec_loop_state vls_checker #(.XLEN(XLEN)) i_vls_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .step(step), .rsp_valid(rsp_valid), .illegal(illegal), .done(done),
  .state_word(state_word), .elem_count(elem_count), .src_idx(src_idx),
  .dst_idx(dst_idx), .sub_idx(sub_idx)
);

// File: tb/test_vec_loop_state.sv
module test_vec_loop_state;
  import vls_pkg::*;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [2:0]      req_op = '0;
  logic [XLEN-1:0] req_wdata = '0;
  logic [XLEN-1:0] vl_reg_value = '0;
  logic            step = 1'b0;
  logic            rsp_valid, illegal, done, scalar_mode;
  logic [XLEN-1:0] rsp_data, state_word;
  logic [5:0]      elem_count, src_idx, dst_idx;
  logic [1:0]      sub_idx;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vec_loop_state #(.XLEN(XLEN)) i_vec_loop_state (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_wdata(req_wdata), .vl_reg_value(vl_reg_value), .step(step),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .illegal(illegal),
    .done(done), .state_word(state_word), .elem_count(elem_count),
    .src_idx(src_idx), .dst_idx(dst_idx), .sub_idx(sub_idx),
    .scalar_mode(scalar_mode)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] wd;
    logic [31:0] sr;
    logic [31:0] rsp;
    logic        ill;
    logic [5:0]  cnt;
  } vec_t;

  localparam logic [31:0] W_MESSY = 32'd63 | (32'd40 << 6) | (32'd9 << 12) |
                                    (32'd2 << 18) | (32'd2 << 24) |
                                    (32'd3 << 26) | 32'hF000_0000;
  localparam logic [31:0] E_MESSY = 32'd32 | (32'd31 << 6) | (32'd4 << 12) |
                                    (32'd2 << 18) | (32'd2 << 24) | (32'd2 << 26);
  localparam logic [31:0] E_VL7   = 32'd32 | (32'd7 << 6) | (32'd2 << 12) |
                                    (32'd2 << 18) | (32'd2 << 24) | (32'd2 << 26);
  localparam logic [31:0] E_SV1   = 32'd32 | (32'd7 << 6) | (32'd2 << 12) |
                                    (32'd2 << 18) | (32'd1 << 24) | (32'd1 << 26);
  localparam logic [31:0] E_MV2   = 32'd2 | (32'd7 << 6) | (32'd1 << 12) |
                                    (32'd1 << 18) | (32'd1 << 24) | (32'd1 << 26);

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 32'd0,     32'd0,  32'd32,  1'b0, 6'd1},  // R10 get max
    '{3'd3, 32'd16,    32'd0,  32'd32,  1'b0, 6'd1},  // R6 old value
    '{3'd3, 32'd40,    32'd0,  32'd16,  1'b0, 6'd1},  // R6 min keeps 16
    '{3'd2, 32'd0,     32'd0,  32'd16,  1'b0, 6'd1},  // R6
    '{3'd3, 32'd0,     32'd0,  32'd16,  1'b0, 6'd1},  // R6 floor at 1
    '{3'd1, W_MESSY,   32'd5,  32'd1,   1'b0, 6'd5},  // R3 R4 R5
    '{3'd0, 32'd0,     32'd0,  E_MESSY, 1'b0, 6'd5},  // R2 R3 R4 R5
    '{3'd4, 32'd0,     32'd0,  32'd31,  1'b0, 6'd5},  // R4
    '{3'd6, 32'd0,     32'd0,  32'd2,   1'b0, 6'd5},  // R9
    '{3'd5, 32'd7,     32'd40, 32'd31,  1'b1, 6'd5},  // R8 above max
    '{3'd5, 32'd33,    32'd3,  32'd31,  1'b1, 6'd5},  // R8 bad number
    '{3'd5, 32'd7,     32'd0,  32'd31,  1'b1, 6'd5},  // R8 zero contents
    '{3'd5, 32'd7,     32'd3,  32'd7,   1'b0, 6'd3},  // R7 new value
    '{3'd0, 32'd0,     32'd0,  E_VL7,   1'b0, 6'd3},  // R7 offsets pulled
    '{3'd7, 32'h0FD,   32'd0,  32'd2,   1'b0, 6'd3},  // R9 old code
    '{3'd0, 32'd0,     32'd0,  E_SV1,   1'b0, 6'd3},  // R9 code 1
    '{3'd3, 32'd2,     32'd0,  32'd32,  1'b0, 6'd2},  // R6 count pulled
    '{3'd0, 32'd0,     32'd0,  E_MV2,   1'b0, 6'd2}   // R6
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] op, input logic [31:0] wd,
                        input logic [31:0] sr, input logic stp);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wdata = wd; vl_reg_value = sr; step = stp;
    @(negedge clk);
    req_valid = 1'b0; step = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 state", state_word, 32'd32);
    check("R1 count", 32'(elem_count), 32'd1);
    check("R1 flags", {29'd0, rsp_valid, illegal, done}, 32'd0);
    check("R13 scalar after reset", 32'(scalar_mode), 32'd1);

    for (int i = 0; i < NV; i++) begin
      do_req(VECS[i].op, VECS[i].wd, VECS[i].sr, 1'b0);
      check($sformatf("R10 valid vec%0d", i), 32'(rsp_valid), 32'd1);
      check($sformatf("R6-9 rsp vec%0d", i), rsp_data, VECS[i].rsp);
      check($sformatf("R8 illegal vec%0d", i), 32'(illegal), 32'(VECS[i].ill));
      check($sformatf("R4 count vec%0d", i), 32'(elem_count), 32'(VECS[i].cnt));
    end
    @(negedge clk);
    check("R8 illegal one cycle", 32'(illegal), 32'd0);

    // R11 R12 nested loop: count 3, sub size 2
    do_reset();
    do_req(3'd1, 32'd32 | (32'd3 << 6) | (32'd1 << 24), 32'd3, 1'b0);
    check("R11 start", {20'd0, src_idx, dst_idx}, 32'd0);
    for (int k = 1; k <= 5; k++) begin
      do_step();
      check($sformatf("R11 src step%0d", k), 32'(src_idx), 32'(k / 2));
      check($sformatf("R11 dst step%0d", k), 32'(dst_idx), 32'(k / 2));
      check($sformatf("R11 sub step%0d", k), 32'(sub_idx), 32'(k % 2));
      check($sformatf("R12 no done step%0d", k), 32'(done), 32'd0);
    end
    do_step();
    check("R12 done pulse", 32'(done), 32'd1);
    check("R12 offsets zero", {18'd0, src_idx, dst_idx, sub_idx}, 32'd0);
    @(negedge clk);
    check("R12 done one cycle", 32'(done), 32'd0);

    // R13 step during a request is ignored
    do_req(3'd4, 32'd0, 32'd0, 1'b1);
    check("R13 step ignored sub", 32'(sub_idx), 32'd0);
    check("R13 step ignored rsp", rsp_data, 32'd3);

    // R11 destination offset wraps independently
    do_req(3'd1, 32'd32 | (32'd3 << 6) | (32'd2 << 18), 32'd3, 1'b0);
    do_step();
    check("R11 dst wrap src", 32'(src_idx), 32'd1);
    check("R11 dst wrap dst", 32'(dst_idx), 32'd0);
    do_step();
    check("R11 dst next", 32'(dst_idx), 32'd1);
    do_step();
    check("R12 done dst case", 32'(done), 32'd1);

    // R13 scalar mode through pointer zero
    do_req(3'd5, 32'd0, 32'd50, 1'b0);
    check("R7 zero pointer rsp", rsp_data, 32'd0);
    check("R13 scalar mode", 32'(scalar_mode), 32'd1);
    check("R13 scalar count", 32'(elem_count), 32'd1);
    do_step();
    check("R13 scalar done each step", 32'(done), 32'd1);

    // R2 reserved bits after write of all ones
    do_req(3'd1, 32'hFFFF_FFFF, 32'd4, 1'b0);
    check("R2 rsvd zero", state_word & 32'hF000_0000, 32'd0);
    check("R3 maxvl cap", state_word & 32'h3F, 32'd32);
    check("R5 dsv limit", (state_word >> 26) & 32'h3, 32'd3);

    finish_run();
  end
endmodule